// File: doc/BRIEF.md
# Counter-Value-Gated Random Bit Filter

This block sits behind a metastability-based random source that is held near its balance point by an integrating counter. Every raw bit arrives with the counter value that was in force when the bit was produced. The filter keeps a small set of counters for a short run of neighbouring counter values. For each value it records how often it occurred and how many ones it produced during a fixed-length window. At the end of each window it decides which values are balanced. In the following window it forwards only the bits that come from those values. Bits from skewed values, or from values outside the tracked run, are dropped. The result is a thinner stream with less bias. It still needs a debiasing post-processor downstream.

The tracked run is `SLOTS` consecutive values starting at a base. The first valid input sets a provisional base `SLOTS/2` below its own counter value. When the first window closes, the base is re-centred so that the value seen most often in that window sits at slot `SLOTS/2`. After that the base does not move. Nothing is forwarded until the first window has closed.

Top module: `gated_bit_filter`

## Requirements
- R1: After reset `out_valid` is 0, and no bit is forwarded before the first window of `WIN` valid inputs has closed.
- R2: The provisional base is the first valid input's counter value minus `SLOTS/2`. At the close of the first window the base becomes provisional base + m − `SLOTS/2`, where m is the lowest slot index with the highest occurrence count. The base is fixed from then on.
- R3: A tracked value is marked as passing at a window close when its occurrence count o and ones count k in that window satisfy |2k − o| ≤ `cfg_band` and o ≥ `cfg_min_occ`. Values that do not meet this are marked as blocked.
- R4: A bit whose counter value minus the base (modulo 2^`CW`) is `SLOTS` or more is never forwarded.
- R5: The marks produced at the close of window w govern every input of window w+1. This includes the input that closes window w+1.
- R6: A forwarded bit appears one clock after its input, with `out_valid` high and `out_bit` equal to the input bit.
- R7: A cycle with `in_valid` low forwards nothing and does not change any tally or window position.
- R8: A value that occurred fewer than `cfg_min_occ` times in a window is blocked, even if its ones count is exactly half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Raw bit present this cycle |
| in_bit | input | 1 | Raw random bit |
| in_cnt | input | CW | Feedback counter value that produced the bit |
| cfg_band | input | $clog2(WIN+1) | Allowed value of \|2·ones − occurrences\| |
| cfg_min_occ | input | $clog2(WIN+1) | Minimum occurrences needed to pass |
| out_valid | output | 1 | Forwarded bit present |
| out_bit | output | 1 | Forwarded bit |

## Verification
The counter value follows a random walk over seven neighbouring values. Each value has its own ones probability, from balanced at the centre to strongly skewed at the edges, so the gate sees clearly different outcomes per value. The first input is placed below the most frequent value. Bits that pass only after the base has been re-centred therefore show whether re-centring happened. Occasional far-away values test the range drop. Windows with a zero band, a very wide band and a high minimum occurrence count separate the band test from the occurrence threshold. Random gaps in `in_valid` confirm that idle cycles leave the window position untouched.

// File: rtl/gated_bit_filter.sv
module gated_bit_filter #(
  parameter int CW    = 12,
  parameter int SLOTS = 8,
  parameter int WIN   = 256,
  localparam int OW   = $clog2(WIN + 1),
  localparam int WCW  = $clog2(WIN),
  localparam int SW   = $clog2(SLOTS),
  localparam int HALF = SLOTS / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_bit,
  input  logic [CW-1:0] in_cnt,
  input  logic [OW-1:0] cfg_band,
  input  logic [OW-1:0] cfg_min_occ,
  output logic          out_valid,
  output logic          out_bit
);

  logic             based, armed;
  logic [CW-1:0]    base;
  logic [WCW-1:0]   wcnt;
  logic [OW-1:0]    occ  [SLOTS];
  logic [OW-1:0]    ones [SLOTS];
  logic [SLOTS-1:0] flags;

  wire [CW-1:0] eff_base = based ? base : in_cnt - CW'(HALF);
  wire [CW-1:0] off      = in_cnt - eff_base;
  wire          inr      = off < CW'(SLOTS);
  wire [SW-1:0] slot     = off[SW-1:0];
  wire          win_end  = in_valid && (wcnt == WCW'(WIN - 1));

  logic [OW-1:0]     occ_n  [SLOTS];
  logic [OW-1:0]     ones_n [SLOTS];
  logic [SLOTS-1:0]  good, nflags;
  logic [SW-1:0]     best;
  logic signed [OW+1:0] d;
  logic              hit;
  int                src;

  always_comb begin
    best = '0;
    for (int i = 0; i < SLOTS; i++) begin
      hit       = in_valid && inr && (slot == SW'(i));
      occ_n[i]  = occ[i] + OW'(hit);
      ones_n[i] = ones[i] + OW'(hit && in_bit);
      d         = $signed({1'b0, ones_n[i], 1'b0}) - $signed({2'b00, occ_n[i]});
      if (d < 0) d = -d;
      good[i]   = (occ_n[i] >= cfg_min_occ) && (d <= $signed({2'b00, cfg_band}));
    end
    for (int i = 1; i < SLOTS; i++)
      if (occ_n[i] > occ_n[best]) best = SW'(i);
    for (int j = 0; j < SLOTS; j++) begin
      src       = armed ? j : j + int'(best) - HALF;
      nflags[j] = 1'b0;
      if (src >= 0 && src < SLOTS) nflags[j] = good[src];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      based     <= 1'b0;
      armed     <= 1'b0;
      base      <= '0;
      wcnt      <= '0;
      flags     <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
        occ[i]  <= '0;
        ones[i] <= '0;
      end
    end else begin
      out_valid <= in_valid && armed && inr && flags[slot];
      out_bit   <= in_bit;
      if (in_valid) begin
        wcnt <= win_end ? '0 : wcnt + WCW'(1);
        for (int i = 0; i < SLOTS; i++) begin
          occ[i]  <= win_end ? '0 : occ_n[i];
          ones[i] <= win_end ? '0 : ones_n[i];
        end
        if (!based) begin
          based <= 1'b1;
          base  <= eff_base;
        end
        if (win_end) begin
          flags <= nflags;
          armed <= 1'b1;
          if (!armed) base <= eff_base + CW'(best) - CW'(HALF);
        end
      end
    end
  end

  p_quiet_until_armed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !out_valid);
  p_base_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(base));
  p_window_wraps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (wcnt == '0) && armed);
  p_bit_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_bit == $past(in_bit));
  p_needs_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(wcnt));

endmodule

// File: tb/sim_gated_bit_filter.sv
module sim_gated_bit_filter;
  localparam int CW = 12, SLOTS = 8, WIN = 256, OW = $clog2(WIN + 1);
  localparam int NWIN = 12;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_bit;
  logic [CW-1:0] in_cnt;
  logic [OW-1:0] band, minocc;
  logic out_valid, out_bit;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gated_bit_filter #(.CW(CW), .SLOTS(SLOTS), .WIN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_cnt(in_cnt), .cfg_band(band), .cfg_min_occ(minocc),
    .out_valid(out_valid), .out_bit(out_bit));

  int m_occ[SLOTS], m_ones[SLOTS], p_occ[SLOTS];
  bit m_flag[SLOTS];
  int m_base, m_base0, m_w;
  bit m_based, m_armed;

  function automatic bit passes(int o, int k);
    int d = 2 * k - o;
    if (d < 0) d = -d;
    return (o >= int'(minocc)) && (d <= int'(band));
  endfunction

  task automatic model(input bit v, input bit b, input int c,
                       output bit ev, output string tag);
    int eb, off, best, src;
    bit inr;
    ev = 0; tag = "R7";
    if (!v) return;
    eb  = m_based ? m_base : ((c - SLOTS/2) & 4095);
    off = (c - eb) & 4095;
    inr = off < SLOTS;
    if (!m_armed) tag = "R1";
    else if (!inr) tag = "R4";
    else begin
      ev = m_flag[off];
      if (ev) tag = (((c - m_base0) & 4095) >= SLOTS) ? "R2" : "R3";
      else    tag = (p_occ[off] < int'(minocc)) ? "R8" : "R3";
    end
    if (m_w == WIN - 1) tag = "R5";
    if (!m_based) begin m_based = 1; m_base = eb; m_base0 = eb; end
    if (inr) begin m_occ[off]++; m_ones[off] += int'(b); end
    m_w++;
    if (m_w == WIN) begin
      best = 0;
      for (int i = 1; i < SLOTS; i++) if (m_occ[i] > m_occ[best]) best = i;
      for (int j = 0; j < SLOTS; j++) begin
        src = m_armed ? j : j + best - SLOTS/2;
        m_flag[j] = 0; p_occ[j] = 0;
        if (src >= 0 && src < SLOTS) begin
          m_flag[j] = passes(m_occ[src], m_ones[src]);
          p_occ[j]  = m_occ[src];
        end
      end
      if (!m_armed) m_base = (m_base + best - SLOTS/2) & 4095;
      for (int i = 0; i < SLOTS; i++) begin m_occ[i] = 0; m_ones[i] = 0; end
      m_armed = 1; m_w = 0;
    end
  endtask

  function automatic bit gen_bit(int c);
    int d = (c > 700) ? c - 700 : 700 - c;
    int thr = (d == 0) ? 50 : (d == 1) ? 62 : (d == 2) ? 80 : 95;
    bit r = (($urandom % 100) < thr);
    return (c < 700) ? ~r : r;
  endfunction

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit pv, pb, ev, have, v, b;
    string ptag, tag;
    int c, nvalid, wi;
    void'($urandom(32'd2024));
    rst_n = 0; in_valid = 0; in_bit = 0; in_cnt = '0; band = 9'd20; minocc = 9'd4;
    m_based = 0; m_armed = 0; m_w = 0;
    for (int i = 0; i < SLOTS; i++) begin
      m_occ[i] = 0; m_ones[i] = 0; p_occ[i] = 0; m_flag[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R1 reset: out_valid actual=%b expected=0", out_valid);
    end
    have = 0; nvalid = 0; c = 697; pv = 0; pb = 0; ptag = "";
    while (nvalid < NWIN * WIN) begin
      if (have) begin
        checks++;
        if (out_valid !== pv) begin
          fails++;
          $display("FAIL %s out_valid actual=%b expected=%b", ptag, out_valid, pv);
        end
        if (pv) begin
          checks++;
          if (out_bit !== pb) begin
            fails++; $display("FAIL R6 out_bit actual=%b expected=%b", out_bit, pb);
          end
        end
      end
      wi = nvalid / WIN;
      band   = (wi == 3) ? 9'd0 : (wi == 5) ? 9'd500 : 9'd20;
      minocc = (wi == 4) ? 9'd60 : 9'd4;
      if (nvalid == 0) begin
        v = 1; c = 697;
      end else begin
        v = ($urandom % 8) != 0;
        if (wi == 0) c = (($urandom % 10) < 4) ? 700 : 697 + int'($urandom % 7);
        else begin
          c = c + int'($urandom % 3) - 1;
          if (c < 697) c = 697;
          if (c > 703) c = 703;
        end
      end
      b = gen_bit(c);
      if (wi > 0 && ($urandom % 20) == 0) begin
        in_cnt = CW'(720);
        model(v, b, 720, ev, tag);
      end else begin
        in_cnt = CW'(c);
        model(v, b, c, ev, tag);
      end
      in_valid = v; in_bit = b;
      if (v) nvalid++;
      pv = ev; pb = b; ptag = tag; have = 1;
      @(negedge clk);
    end
    checks++;
    if (out_valid !== pv) begin
      fails++; $display("FAIL %s out_valid actual=%b expected=%b", ptag, out_valid, pv);
    end
    in_valid = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R7 idle: out_valid actual=%b expected=0", out_valid);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule